// File: doc/BRIEF.md
# Push-Button LED Pattern Sequencer

The block drives four LEDs with one of four display patterns. A push-button steps through the patterns. A free-running divider makes a one-cycle enable pulse, called the update tick, every `TICK_CYCLES` system clocks. In hardware this is 25,000,000 cycles at 100 MHz, which is one update every 250 ms. All other state in the block moves only on that pulse:

- the synchronized buttons are sampled;
- a press of button 0 is detected against the previous sample;
- the pattern is refreshed.

Because the buttons are looked at only once per tick, contact bounce shorter than a tick period is filtered out. A press that lasts over many ticks advances the pattern only once.

The patterns are, in cycling order:

- dark;
- fully lit;
- a single lit LED that walks upward;
- a live copy of the buttons.

The walking position is kept while another pattern is shown. When the walking pattern returns, it resumes from the position where it stopped.

Top module: `led_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after reset, `led_o` is 0000, the pattern is dark (mode 0), the walking position is 0 and the stored button sample is 0.
- R2: The update tick fires every `TICK_CYCLES` clocks, and the first one falls on the `TICK_CYCLES`-th rising edge after reset is released. `led_o` is registered and changes only on the edge that consumes a tick. It is stable at every other time.
- R3: The modes follow the order 0 dark, 1 all lit (1111), 2 walking, 3 mirror. Each rising edge of button 0 (`btn_i[0]`) between two consecutive tick samples advances the mode by one. The mode wraps from 3 to 0.
- R4: Button 0 held high across several ticks advances the mode exactly once. A new advance needs a sample with button 0 low first.
- R5: Buttons pass through a two-flop synchronizer and are seen only at a tick. A press that is gone by the tick sample, or that arrives less than two clocks before the tick, has no effect at that tick.
- R6: In walking mode `led_o` is the value 1 shifted left by a 2-bit position, so position 0 gives 0001 and position 3 gives 1000. The current position is shown on the tick, and then the position increments. It wraps from 3 to 0.
- R7: The walking position changes only on ticks spent in walking mode. Its value is kept across mode changes away from walking and back.
- R8: In mirror mode `led_o[i]` equals `btn_i[i]` as sampled on that tick.
- R9: Buttons 1 to 3 never change the mode. They appear only in mirror mode.
- R10: A mode advance is shown on the same tick that detects the press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 4 | Raw push-button levels, 1 = pressed |
| led_o | output | 4 | LED drive, 1 = lit |

## Verification
The bench builds the block with `TICK_CYCLES` = 8 and keeps the default of four LEDs and two synchronizer stages. An 8-clock tick lets the bench work at tick level within a few hundred cycles:

- walk the full four-mode cycle with its wrap;
- step the walking LED several times around its ring;
- leave walking mode and return.

It is still long enough to place a short glitch between two samples, and a press in the last clock before a tick, where the synchronizer latency decides the outcome.

// File: rtl/led_mode_pkg.sv
package led_mode_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ON     = 2'd1,
    MODE_WALK   = 2'd2,
    MODE_MIRROR = 2'd3
  } led_mode_e;

  function automatic led_mode_e mode_succ(led_mode_e m);
    return led_mode_e'(m + 2'd1);
  endfunction

endpackage

// File: rtl/lmc_tick_gen.sv
module lmc_tick_gen #(
  parameter int unsigned PERIOD = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/lmc_btn_sampler.sv
module lmc_btn_sampler #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] btn_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o,
  output logic             press_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             sample_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q[0] <= btn_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], btn_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_q <= '0;
    else if (tick_i) sample_q <= sync_o;
  end

  assign prev_o  = sample_q;
  // edge of button 0 between two tick samples
  assign press_o = tick_i & sync_o[0] & ~sample_q[0];

  p_press_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> prev_o[0]);
  p_sample_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(prev_o));
endmodule

// File: rtl/lmc_mode_ctrl.sv
module lmc_mode_ctrl
  import led_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      press_i,
  output led_mode_e mode_o,
  output led_mode_e mode_next_o
);
  led_mode_e mode_q;

  assign mode_next_o = press_i ? mode_succ(mode_q) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_next_o;
  end

  assign mode_o = mode_q;

  p_mode_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_i |=> mode_q == mode_succ($past(mode_q)));
  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !press_i |=> $stable(mode_q));
endmodule

// File: rtl/lmc_pattern_gen.sv
module lmc_pattern_gen
  import led_mode_pkg::*;
#(
  parameter int unsigned NUM_LED = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  led_mode_e          mode_i,
  input  logic [NUM_LED-1:0] btn_i,
  output logic [NUM_LED-1:0] led_o
);
  localparam int unsigned PW = (NUM_LED > 2) ? $clog2(NUM_LED) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(NUM_LED - 1);

  logic [PW-1:0]      pos_q;
  logic [NUM_LED-1:0] walk_vec;
  logic [NUM_LED-1:0] pat;
  logic [NUM_LED-1:0] led_q;

  generate
    for (genvar i = 0; i < NUM_LED; i++) begin : g_walk
      assign walk_vec[i] = (pos_q == PW'(i));
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      MODE_OFF:  pat = '0;
      MODE_ON:   pat = '1;
      MODE_WALK: pat = walk_vec;
      default:   pat = btn_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q <= '0;
      pos_q <= '0;
    end else if (tick_i) begin
      led_q <= pat;
      if (mode_i == MODE_WALK)
        pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
    end
  end

  assign led_o = led_q;

  p_walk_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_WALK) |=> $countones(led_o) == 1);
  p_walk_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && mode_i == MODE_WALK) |=> $stable(pos_q));
  p_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_MIRROR) |=> led_o == $past(btn_i));
endmodule

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl
  import led_mode_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 25_000_000,
  parameter int unsigned NUM_LED     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LED-1:0] btn_i,
  output logic [NUM_LED-1:0] led_o
);
  logic               tick;
  logic               press;
  logic [NUM_LED-1:0] btn_sync;
  logic [NUM_LED-1:0] btn_prev;
  led_mode_e          mode_cur;
  led_mode_e          mode_next;

  lmc_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  lmc_btn_sampler #(.WIDTH(NUM_LED), .STAGES(SYNC_STAGES)) u_btn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .btn_i   (btn_i),
    .sync_o  (btn_sync),
    .prev_o  (btn_prev),
    .press_o (press)
  );

  lmc_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .press_i     (press),
    .mode_o      (mode_cur),
    .mode_next_o (mode_next)
  );

  lmc_pattern_gen #(.NUM_LED(NUM_LED)) u_pat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .mode_i (mode_next),
    .btn_i  (btn_sync),
    .led_o  (led_o)
  );

  p_led_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick) |-> $stable(led_o));
  p_mode_only_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(mode_cur));
  p_held_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && btn_prev[0]) |=> $stable(mode_cur));
endmodule

// File: tb/led_mode_ctrl_test.sv
module led_mode_ctrl_test;
  localparam int unsigned T = 8;
  localparam int NSTEP = 27;
  // {req code, buttons held for one tick interval, expected led after tick}
  localparam logic [11:0] STEPS [NSTEP] = '{
    12'h300, 12'h31F, 12'h41F, 12'h41F, 12'h30F, 12'hA11, 12'h602, 12'h604,
    12'h608, 12'h601, 12'h811, 12'h8AA, 12'h9EE, 12'h3F0, 12'h9E0, 12'h31F,
    12'h30F, 12'h712, 12'h604, 12'h811, 12'h866, 12'h370, 12'h410, 12'h400,
    12'h31F, 12'h30F, 12'h718
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] btn = 4'b0000;
  logic [3:0] led;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  led_mode_ctrl #(.TICK_CYCLES(T), .NUM_LED(4), .SYNC_STAGES(2)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .btn_i  (btn),
    .led_o  (led)
  );

  function automatic string req_tag(logic [3:0] c);
    case (c)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: led=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one tick interval: drive buttons, check hold mid-way (R2), check update
  task automatic step(logic [3:0] b, logic [3:0] prev, logic [3:0] exp, string req);
    btn = b;
    repeat (T / 2) @(negedge clk);
    check("R2", led, prev);
    repeat (T - T / 2) @(negedge clk);
    check(req, led, exp);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: led=%b expected=done", led);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    repeat (3) @(negedge clk);
    check("R1", led, 4'b0000);
    rst_n = 1'b1;
    prev = 4'b0000;
    for (int i = 0; i < NSTEP; i++) begin
      step(STEPS[i][7:4], prev, STEPS[i][3:0], req_tag(STEPS[i][11:8]));
      prev = STEPS[i][3:0];
    end
    // walking resumes: pos 0 shown
    step(4'b0000, prev, 4'b0001, "R6");
    // R5: short glitch well before the tick is not seen
    btn = 4'b0001;
    repeat (2) @(negedge clk);
    btn = 4'b0000;
    repeat (T - 2) @(negedge clk);
    check("R5", led, 4'b0010);
    // R5: press one clock before the tick misses this sample
    repeat (T - 1) @(negedge clk);
    btn = 4'b0001;
    @(negedge clk);
    check("R5", led, 4'b0100);
    // R3: still held, caught at the next tick -> mirror
    step(4'b0001, 4'b0100, 4'b0001, "R3");
    // R1: mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", led, 4'b0000);
    btn = 4'b0000;
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0000, 4'b0000, 4'b0000, "R1");
    step(4'b0001, 4'b0000, 4'b1111, "R1");
    step(4'b0000, 4'b1111, 4'b1111, "R3");
    step(4'b0001, 4'b1111, 4'b0001, "R1"); // walking restarts at position 0
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule